// File: doc/BRIEF.md
# Blue-Screen Raster Source

This block is the head of a chain of standard-definition video stages. It produces a solid blue picture as a stream of 8-bit YCbCr 4:2:2 bytes, one byte per accepted beat. Each byte comes with sideband fields that tell later stages where it sits in the frame: a frame-start flag, an interlaced picture line number, a sample position within the line and a three-bit field/vertical/horizontal blanking vector. A later stage can compare these fields against its own window and replace bytes to overlay graphics.

A static `pal_mode` pin picks the 625-line raster (1728 beats per line) or the 525-line raster (1716 beats per line). A synchronous reset returns the raster to the first beat of field 1. The output is a valid/ready stream. `vid_valid` follows the `en` pin. A beat is consumed on a rising clock edge where both `vid_valid` and `vid_ready` are high. While the sink holds `vid_ready` low, or while `en` is low, the raster stays where it is and every output keeps its value.

Top module: `sdv_blue_source`

## Requirements
- R1: After a synchronous reset, the presented beat is the frame's first: `vid_tof`=1, `vid_sample`=0, `vid_fvh`=3'b010, `vid_data`=0x80, and `vid_line` holds the last line number of field 2 (575 for 625 lines, 479 for 525 lines).
- R2: `vid_valid` equals `en`. The raster advances by exactly one beat on each edge where `vid_valid` and `vid_ready` are both high. On any other edge, all stream outputs stay unchanged.
- R3: A line is `H_ACTIVE` (1440) active beats with `vid_sample` counting 0 upward and H (`vid_fvh[0]`) low. The remaining beats of the line have H high and `vid_sample` held at 1439.
- R4: A frame is 625 lines (625-line mode) or 525 lines (525-line mode). `vid_tof` is high only on the first beat of line 0, so it rises once per frame.
- R5: F (`vid_fvh[2]`) is 0 for the first 312 (625-line) or 262 (525-line) lines of the frame and 1 for the rest.
- R6: V (`vid_fvh[1]`) is 1 for the first 24 lines of field 1 and the first 25 lines of field 2 in 625-line mode. In 525-line mode it is 1 for the first 22 and 23 lines. It is 0 elsewhere.
- R7: On active lines, `vid_line` is 2k in field 1 and 2k+1 in field 2, where k is the active-line index within the field. During V it holds the last active value: 2N-1 in field 1 and 2N-2 in field 2, where N is the active lines per field.
- R8: Active bytes repeat Cb, Y, Cr, Y starting with Cb at sample 0, with Cb=0xF0, Y=0x29 and Cr=0x6E.
- R9: When H or V is high, even-position beats carry 0x80 and odd-position beats carry 0x10.
- R10: `pal_mode`=1 selects 1728 beats per line and 625 lines; `pal_mode`=0 selects 1716 beats per line and 525 lines. The pin changes only while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Stream enable; low freezes the raster |
| pal_mode | input | 1 | 1 = 625-line raster, 0 = 525-line raster |
| vid_ready | input | 1 | Sink accepts the presented beat |
| vid_valid | output | 1 | Presented beat is valid |
| vid_data | output | DW (8) | YCbCr byte |
| vid_tof | output | 1 | First beat of the frame |
| vid_line | output | LW (10) | Interlaced picture line number |
| vid_sample | output | SW (11) | Position within the active line |
| vid_fvh | output | 3 | {field, vertical blank, horizontal blank} |

## Verification
The hardest part to reach is the frame wrap and the field 1 to field 2 boundary. At full size, that takes over a million accepted beats. A second instance therefore has the raster shrunk through its parameters. The bench drives it through many whole frames in both modes, with random stalls on `en` and `vid_ready`. A default-size instance shares the same stimulus and is checked beat by beat far enough to cross from vertical blanking into the first active lines. This confirms the real line length and the active-line numbering.

// File: rtl/sdv_raster_pkg.sv
package sdv_raster_pkg;

  typedef struct packed {
    logic field;
    logic vblank;
    logic hblank;
  } fvh_t;

  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_YA = 2'd1,
    PH_CR = 2'd2,
    PH_YB = 2'd3
  } byte_phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdv_line_timer.sv
module sdv_line_timer #(
  parameter int H_ACTIVE     = 1440,
  parameter int PAL_H_TOTAL  = 1728,
  parameter int NTSC_H_TOTAL = 1716,
  parameter int HCW          = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pal_mode,
  input  logic           adv,
  output logic [HCW-1:0] h_cnt,
  output logic           hblank,
  output logic           line_end
);

  localparam logic [HCW-1:0] HLAST_P = HCW'(PAL_H_TOTAL - 1);
  localparam logic [HCW-1:0] HLAST_N = HCW'(NTSC_H_TOTAL - 1);
  localparam logic [HCW-1:0] HACT    = HCW'(H_ACTIVE);

  logic [HCW-1:0] h_last;

  assign h_last   = pal_mode ? HLAST_P : HLAST_N;
  assign line_end = (h_cnt >= h_last);
  assign hblank   = (h_cnt >= HACT);

  always_ff @(posedge clk) begin
    if (rst)      h_cnt <= '0;
    else if (adv) h_cnt <= line_end ? '0 : h_cnt + 1'b1;
  end

  AST_H_BOUND: assert property (@(posedge clk) disable iff (rst)
    h_cnt <= h_last); // R3
  AST_H_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(h_cnt)); // R2
  AST_H_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && line_end) |=> (h_cnt == '0)); // R3

endmodule

// File: rtl/sdv_frame_timer.sv
module sdv_frame_timer #(
  parameter int PAL_ACTIVE_LINES  = 576,
  parameter int PAL_F1_VBLANK     = 24,
  parameter int PAL_F2_VBLANK     = 25,
  parameter int NTSC_ACTIVE_LINES = 480,
  parameter int NTSC_F1_VBLANK    = 22,
  parameter int NTSC_F2_VBLANK    = 23,
  parameter int VCW               = 10,
  parameter int LW                = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pal_mode,
  input  logic          step,
  output logic          field,
  output logic          vblank,
  output logic [LW-1:0] line_num,
  output logic          frame_top
);

  localparam int N_P     = PAL_ACTIVE_LINES / 2;
  localparam int N_N     = NTSC_ACTIVE_LINES / 2;
  localparam int F1LEN_P = PAL_F1_VBLANK + N_P;
  localparam int F1LEN_N = NTSC_F1_VBLANK + N_N;
  localparam int F2ACT_P = F1LEN_P + PAL_F2_VBLANK;
  localparam int F2ACT_N = F1LEN_N + NTSC_F2_VBLANK;
  localparam int TOT_P   = F2ACT_P + N_P;
  localparam int TOT_N   = F2ACT_N + N_N;

  localparam logic [VCW-1:0] C_F1B_P  = VCW'(PAL_F1_VBLANK);
  localparam logic [VCW-1:0] C_F1B_N  = VCW'(NTSC_F1_VBLANK);
  localparam logic [VCW-1:0] C_F1L_P  = VCW'(F1LEN_P);
  localparam logic [VCW-1:0] C_F1L_N  = VCW'(F1LEN_N);
  localparam logic [VCW-1:0] C_F2A_P  = VCW'(F2ACT_P);
  localparam logic [VCW-1:0] C_F2A_N  = VCW'(F2ACT_N);
  localparam logic [VCW-1:0] C_LAST_P = VCW'(TOT_P - 1);
  localparam logic [VCW-1:0] C_LAST_N = VCW'(TOT_N - 1);
  localparam logic [VCW:0]   C_HF1_P  = (VCW+1)'(2 * N_P - 1);
  localparam logic [VCW:0]   C_HF1_N  = (VCW+1)'(2 * N_N - 1);
  localparam logic [VCW:0]   C_HF2_P  = (VCW+1)'(2 * N_P - 2);
  localparam logic [VCW:0]   C_HF2_N  = (VCW+1)'(2 * N_N - 2);

  logic [VCW-1:0] v_cnt;
  logic [VCW-1:0] f1b, f1l, f2a, v_last;
  logic [VCW-1:0] act_idx;
  logic [VCW:0]   pic_line, hold_line;
  logic           v_end;

  assign f1b    = pal_mode ? C_F1B_P  : C_F1B_N;
  assign f1l    = pal_mode ? C_F1L_P  : C_F1L_N;
  assign f2a    = pal_mode ? C_F2A_P  : C_F2A_N;
  assign v_last = pal_mode ? C_LAST_P : C_LAST_N;
  assign v_end  = (v_cnt >= v_last);

  always_ff @(posedge clk) begin
    if (rst)       v_cnt <= '0;
    else if (step) v_cnt <= v_end ? '0 : v_cnt + 1'b1;
  end

  always_comb begin
    field     = (v_cnt >= f1l);
    vblank    = field ? (v_cnt < f2a) : (v_cnt < f1b);
    act_idx   = field ? (v_cnt - f2a) : (v_cnt - f1b);
    pic_line  = {act_idx, field};
    if (field) hold_line = pal_mode ? C_HF2_P : C_HF2_N;
    else       hold_line = pal_mode ? C_HF1_P : C_HF1_N;
    line_num  = vblank ? LW'(hold_line) : LW'(pic_line);
    frame_top = (v_cnt == '0);
  end

  AST_V_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && v_end) |=> (v_cnt == '0)); // R4
  AST_FIELD_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(field) |-> frame_top); // R5
  AST_TOP_BLANK: assert property (@(posedge clk) disable iff (rst)
    frame_top |-> (vblank && !field)); // R6

endmodule

// File: rtl/sdv_colour_gen.sv
module sdv_colour_gen
  import sdv_raster_pkg::*;
#(
  parameter int             DW      = 8,
  parameter logic [DW-1:0]  Y_BLUE  = 8'h29,
  parameter logic [DW-1:0]  CB_BLUE = 8'hF0,
  parameter logic [DW-1:0]  CR_BLUE = 8'h6E,
  parameter logic [DW-1:0]  Y_BLANK = 8'h10,
  parameter logic [DW-1:0]  C_BLANK = 8'h80
) (
  input  logic [1:0]    phase_bits,
  input  logic          blank,
  output logic [DW-1:0] data
);

  byte_phase_e phase;

  assign phase = byte_phase_e'(phase_bits);

  always_comb begin
    if (blank) begin
      data = phase_bits[0] ? Y_BLANK : C_BLANK;
    end else begin
      unique case (phase)
        PH_CB:   data = CB_BLUE;
        PH_CR:   data = CR_BLUE;
        default: data = Y_BLUE;
      endcase
    end
  end

endmodule

// File: rtl/sdv_blue_source.sv
module sdv_blue_source
  import sdv_raster_pkg::*;
#(
  parameter int            DW                = 8,
  parameter int            LW                = 10,
  parameter int            SW                = 11,
  parameter int            H_ACTIVE          = 1440,
  parameter int            PAL_H_TOTAL       = 1728,
  parameter int            NTSC_H_TOTAL      = 1716,
  parameter int            PAL_ACTIVE_LINES  = 576,
  parameter int            PAL_F1_VBLANK     = 24,
  parameter int            PAL_F2_VBLANK     = 25,
  parameter int            NTSC_ACTIVE_LINES = 480,
  parameter int            NTSC_F1_VBLANK    = 22,
  parameter int            NTSC_F2_VBLANK    = 23,
  parameter logic [DW-1:0] Y_BLUE            = 8'h29,
  parameter logic [DW-1:0] CB_BLUE           = 8'hF0,
  parameter logic [DW-1:0] CR_BLUE           = 8'h6E,
  parameter logic [DW-1:0] Y_BLANK           = 8'h10,
  parameter logic [DW-1:0] C_BLANK           = 8'h80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          pal_mode,
  input  logic          vid_ready,
  output logic          vid_valid,
  output logic [DW-1:0] vid_data,
  output logic          vid_tof,
  output logic [LW-1:0] vid_line,
  output logic [SW-1:0] vid_sample,
  output logic [2:0]    vid_fvh
);

  localparam int HT_MAX  = max2(PAL_H_TOTAL, NTSC_H_TOTAL);
  localparam int VT_MAX  = max2(PAL_ACTIVE_LINES + PAL_F1_VBLANK + PAL_F2_VBLANK,
                                NTSC_ACTIVE_LINES + NTSC_F1_VBLANK + NTSC_F2_VBLANK);
  localparam int HCW     = $clog2(HT_MAX);
  localparam int VCW     = $clog2(VT_MAX);
  localparam logic [SW-1:0] S_HOLD = SW'(H_ACTIVE - 1);

  logic [HCW-1:0] h_cnt;
  logic           hblank, line_end, adv, step;
  logic           field, vblank, frame_top;
  fvh_t           fvh;

  assign adv  = en & vid_ready;
  assign step = adv & line_end;

  sdv_line_timer #(
    .H_ACTIVE     (H_ACTIVE),
    .PAL_H_TOTAL  (PAL_H_TOTAL),
    .NTSC_H_TOTAL (NTSC_H_TOTAL),
    .HCW          (HCW)
  ) u_line (
    .clk      (clk),
    .rst      (rst),
    .pal_mode (pal_mode),
    .adv      (adv),
    .h_cnt    (h_cnt),
    .hblank   (hblank),
    .line_end (line_end)
  );

  sdv_frame_timer #(
    .PAL_ACTIVE_LINES  (PAL_ACTIVE_LINES),
    .PAL_F1_VBLANK     (PAL_F1_VBLANK),
    .PAL_F2_VBLANK     (PAL_F2_VBLANK),
    .NTSC_ACTIVE_LINES (NTSC_ACTIVE_LINES),
    .NTSC_F1_VBLANK    (NTSC_F1_VBLANK),
    .NTSC_F2_VBLANK    (NTSC_F2_VBLANK),
    .VCW               (VCW),
    .LW                (LW)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .pal_mode  (pal_mode),
    .step      (step),
    .field     (field),
    .vblank    (vblank),
    .line_num  (vid_line),
    .frame_top (frame_top)
  );

  sdv_colour_gen #(
    .DW      (DW),
    .Y_BLUE  (Y_BLUE),
    .CB_BLUE (CB_BLUE),
    .CR_BLUE (CR_BLUE),
    .Y_BLANK (Y_BLANK),
    .C_BLANK (C_BLANK)
  ) u_colour (
    .phase_bits (h_cnt[1:0]),
    .blank      (hblank | vblank),
    .data       (vid_data)
  );

  assign fvh        = '{field: field, vblank: vblank, hblank: hblank};
  assign vid_fvh    = fvh;
  assign vid_valid  = en;
  assign vid_sample = hblank ? S_HOLD : SW'(h_cnt);
  assign vid_tof    = frame_top & (h_cnt == '0);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (vid_valid && !vid_ready) |=> ($stable(vid_data) && $stable(vid_line) &&
      $stable(vid_sample) && $stable(vid_fvh) && $stable(vid_tof))); // R2
  AST_TOF_CORNER: assert property (@(posedge clk) disable iff (rst)
    vid_tof |-> (vid_sample == '0 && vid_fvh == 3'b010)); // R4
  AST_H_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(vid_fvh[0]) |-> ($past(vid_sample) == S_HOLD)); // R3
  AST_BLANK_CODE: assert property (@(posedge clk) disable iff (rst)
    (vid_fvh[1:0] != 2'b00) |-> (vid_data == Y_BLANK || vid_data == C_BLANK)); // R9
  AST_ACTIVE_LUMA: assert property (@(posedge clk) disable iff (rst)
    (vid_fvh[1:0] == 2'b00 && vid_sample[0]) |-> (vid_data == Y_BLUE)); // R8

endmodule

// File: tb/sdv_blue_source_bench.sv
`timescale 1ns/1ps
module sdv_blue_source_bench;

  typedef struct {
    int ha; int pht; int nht;
    int pact; int pf1; int pf2;
    int nact; int nf1; int nf2;
  } geo_t;

  typedef struct packed {
    logic [7:0]  d;
    logic        tof;
    logic [9:0]  line;
    logic [10:0] smp;
    logic [2:0]  fvh;
  } beat_t;

  geo_t g_s = '{8, 12, 10, 6, 2, 3, 4, 1, 2};
  geo_t g_f = '{1440, 1728, 1716, 576, 24, 25, 480, 22, 23};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic rdy = 1'b0;
  logic pal = 1'b1;

  logic        vs, tof_s, vf, tof_f;
  logic [7:0]  d_s, d_f;
  logic [9:0]  ln_s, ln_f;
  logic [10:0] sm_s, sm_f;
  logic [2:0]  fvh_s, fvh_f;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] lf = 16'hACE1;
  int sh, sv, fh, fv;
  beat_t q_s[$];
  beat_t q_f[$];
  int frame_cnt = 0;
  bit frame_seen = 0;

  always #4 clk = ~clk;

  sdv_blue_source #(
    .H_ACTIVE(8), .PAL_H_TOTAL(12), .NTSC_H_TOTAL(10),
    .PAL_ACTIVE_LINES(6), .PAL_F1_VBLANK(2), .PAL_F2_VBLANK(3),
    .NTSC_ACTIVE_LINES(4), .NTSC_F1_VBLANK(1), .NTSC_F2_VBLANK(2)
  ) u_sdv_blue_source (
    .clk(clk), .rst(rst), .en(en), .pal_mode(pal), .vid_ready(rdy),
    .vid_valid(vs), .vid_data(d_s), .vid_tof(tof_s), .vid_line(ln_s),
    .vid_sample(sm_s), .vid_fvh(fvh_s)
  );

  sdv_blue_source u_sdv_blue_source_full (
    .clk(clk), .rst(rst), .en(en), .pal_mode(pal), .vid_ready(rdy),
    .vid_valid(vf), .vid_data(d_f), .vid_tof(tof_f), .vid_line(ln_f),
    .vid_sample(sm_f), .vid_fvh(fvh_f)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic beat_t model(input geo_t g, input bit p, input int h, input int v);
    beat_t b;
    int n, f1b, f2b, f1len, f2s;
    bit ff, vv, hh;
    n     = (p ? g.pact : g.nact) / 2;
    f1b   = p ? g.pf1 : g.nf1;
    f2b   = p ? g.pf2 : g.nf2;
    f1len = f1b + n;
    f2s   = f1len + f2b;
    ff    = (v >= f1len);
    vv    = ff ? (v < f2s) : (v < f1b);
    hh    = (h >= g.ha);
    b.fvh = {ff, vv, hh};
    b.tof = (h == 0 && v == 0);
    b.smp = 11'(hh ? g.ha - 1 : h);
    if (vv)      b.line = 10'(ff ? 2 * n - 2 : 2 * n - 1);
    else if (ff) b.line = 10'(2 * (v - f2s) + 1);
    else         b.line = 10'(2 * (v - f1b));
    if (hh || vv) b.d = (h % 2 == 1) ? 8'h10 : 8'h80;
    else begin
      case (h % 4)
        0:       b.d = 8'hF0;
        2:       b.d = 8'h6E;
        default: b.d = 8'h29;
      endcase
    end
    return b;
  endfunction

  function automatic void adv_pos(input geo_t g, input bit p, inout int h, inout int v);
    int ht, vt;
    ht = p ? g.pht : g.nht;
    vt = p ? (g.pact + g.pf1 + g.pf2) : (g.nact + g.nf1 + g.nf2);
    h++;
    if (h == ht) begin
      h = 0;
      v++;
      if (v == vt) v = 0;
    end
  endfunction

  task automatic cmp(input string who, input beat_t a, input beat_t e);
    chk(a.d == e.d, (e.fvh[1:0] != 0) ? "R9" : "R8", {who, " data"}, a.d, e.d);
    chk(a.tof == e.tof, "R4", {who, " tof"}, a.tof, e.tof);
    chk(a.line == e.line, "R7", {who, " line"}, a.line, e.line);
    chk(a.smp == e.smp, "R3", {who, " sample"}, a.smp, e.smp);
    chk(a.fvh[2] == e.fvh[2], "R5", {who, " F"}, a.fvh[2], e.fvh[2]);
    chk(a.fvh[1] == e.fvh[1], "R6", {who, " V"}, a.fvh[1], e.fvh[1]);
    chk(a.fvh[0] == e.fvh[0], "R3", {who, " H"}, a.fvh[0], e.fvh[0]);
  endtask

  task automatic do_reset(input bit p);
    @(negedge clk);
    rst = 1'b1; en = 1'b0; rdy = 1'b0; pal = p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    sh = 0; sv = 0; fh = 0; fv = 0;
    #1;
    // R1: first beat after reset
    chk(tof_s == 1'b1, "R1", "tof after reset", tof_s, 1);
    chk(fvh_s == 3'b010, "R1", "fvh after reset", fvh_s, 2);
    chk(sm_s == 11'd0, "R1", "sample after reset", sm_s, 0);
    chk(d_s == 8'h80, "R1", "data after reset", d_s, 8'h80);
    chk(ln_s == (p ? 10'd5 : 10'd3), "R1", "small line after reset", ln_s, p ? 5 : 3);
    chk(ln_f == (p ? 10'd575 : 10'd479), "R1", "full line after reset", ln_f, p ? 575 : 479);
    chk(tof_f == 1'b1 && fvh_f == 3'b010, "R1", "full tof/fvh after reset", {tof_f, fvh_f}, 4'b1010);
  endtask

  task automatic run(input int cycles);
    repeat (cycles) begin
      @(negedge clk);
      lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      en  = (lf[3:0] != 4'd0);
      rdy = (lf[6:4] != 3'd0);
      #1;
      if (en) begin
        q_s.push_back(model(g_s, pal, sh, sv));
        q_f.push_back(model(g_f, pal, fh, fv));
      end
      if (en && rdy) begin
        adv_pos(g_s, pal, sh, sv);
        adv_pos(g_f, pal, fh, fv);
      end
    end
    @(negedge clk);
    en = 1'b0;
  endtask

  // monitor: pops one expected beat for every beat presented
  always @(negedge clk) begin
    #2;
    if (rst) begin
      frame_seen = 0;
      frame_cnt = 0;
    end else begin
      chk(vs == en, "R2", "valid follows enable", vs, en);
      if (vs) begin
        if (q_s.size() == 0 || q_f.size() == 0) begin
          chk(1'b0, "R2", "beat with empty scoreboard", 0, 1);
        end else begin
          cmp("small", '{d_s, tof_s, ln_s, sm_s, fvh_s}, q_s.pop_front());
          cmp("full", '{d_f, tof_f, ln_f, sm_f, fvh_f}, q_f.pop_front());
        end
        if (rdy) begin
          if (tof_s) begin
            // R10 R4: accepted beats per frame depend on mode
            if (frame_seen)
              chk(frame_cnt == (pal ? 132 : 70), "R10", "frame beat count",
                  frame_cnt, pal ? 132 : 70);
            frame_seen = 1;
            frame_cnt = 0;
          end
          frame_cnt++;
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);   // R10: 625-line mode
    run(60000);
    do_reset(1'b0);   // R10: 525-line mode
    run(60000);
    repeat (2) @(negedge clk);
    chk(q_s.size() == 0, "R2", "small scoreboard drained", q_s.size(), 0);
    chk(q_f.size() == 0, "R2", "full scoreboard drained", q_f.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule